// File: doc/BRIEF.md
# Serial Flash Clock Divider with Duty Correction

This block derives the serial clock for an external flash interface from the faster peripheral clock. A 5-bit divider code selects the serial clock period. Codes below 16 give periods that grow one clock per step. Codes from 16 upward give even periods that grow two clocks per step. An odd period normally leaves the high phase one clock longer than the low phase. An optional correction delays the serial rising edge by half a peripheral clock, so that both phases last the same time.

During transmission, two stretch bits can add one peripheral clock to the low phase or to the high phase, which gives extra setup or hold margin. Alongside the clock, the block produces one-cycle strobes that mark the rising and falling edges for the data shifter next to it. Those strobes follow the undelayed phase counter. The clock idles low while the run enable is low. When enable rises, the clock starts with a complete low phase. All configuration is taken at period boundaries, so a change never cuts a period short.

Top module: `sclk_divider`

## Requirements
- R1: A divider code C from 0 to 15 gives a period of C+2 peripheral clocks. The low phase is floor(P/2) clocks and the high phase is ceil(P/2) clocks, so an odd period is one clock longer in its high phase.
- R2: A divider code C from 16 to 31 gives a period of 2*(C-7) peripheral clocks (18 up to 48), split into equal halves.
- R3: While reset is low, or while run enable is low, the serial clock is 0 and neither strobe is asserted.
- R4: When run enable is driven high between two clock edges, the first rising strobe is seen right after the L-th following rising edge, where L is the low-phase length, and the serial clock stays low until then.
- R5: When duty correction is on and the period is odd, the serial clock rises half a peripheral clock after the undelayed rising edge, and it falls without delay. The result is that both phases last P half-clocks. For an even period the correction bit has no effect.
- R6: When the transmit indicator is high, the setup-stretch bit adds one clock to the low phase and the hold-stretch bit adds one clock to the high phase. When the transmit indicator is low, both bits have no effect.
- R7: The divider code, correction bit, stretch bits and transmit indicator are taken only at the start of a period (and continuously while idle). A period already in progress finishes with its old lengths.
- R8: The rising strobe is high for exactly the first peripheral clock of each undelayed high phase. The falling strobe is high for exactly the first clock of each low phase that follows a high phase. The two strobes are never high together, and duty correction does not move them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Clock generation enable; clock idles low when 0 |
| tx_phase | input | 1 | High while the shifter is transmitting |
| div_code | input | 5 | Divider code (R1, R2 encoding) |
| duty_fix | input | 1 | Half-clock rising-edge delay for odd periods |
| setup_ext | input | 1 | Stretch low phase by one clock during transmit |
| hold_ext | input | 1 | Stretch high phase by one clock during transmit |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | One-clock strobe at each serial rising edge |
| fall_stb | output | 1 | One-clock strobe at each serial falling edge |

## Verification
The strobes and the undelayed clock change on the first rising edge after the edge at which the counter reaches the end of a phase, so they register one clock after that decision. A corrected rising edge appears half a clock after that, on the falling edge of the peripheral clock. The bench therefore samples 1 ns after every edge of the peripheral clock and measures phase widths in half-clocks, which resolves the half-clock delay directly. Latency checks count rising edges from the point where run enable or the divider code is driven, and compare the count with the phase lengths that R1, R2 and R6 predict.

// File: rtl/sclkdiv_pkg.sv
// Package: shared constants, phase type and period helper for the serial
// clock divider. Assumes the divider code encoding described in the brief.
package sclkdiv_pkg;

    // Default divider code width and code table break points.
    localparam int DEF_CODE_W    = 5;
    localparam int DEF_LIN_LIMIT = 16;
    localparam int DEF_LIN_ADD   = 2;
    localparam int DEF_EXT_SUB   = 7;

    // Serial clock phase as seen before any duty correction.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Largest period the code table can produce, in peripheral clocks.
    function automatic int max_period(input int code_w, input int lin_limit,
                                      input int lin_add, input int ext_sub);
        int lin_max;
        int ext_max;
        lin_max = lin_limit - 1 + lin_add;
        ext_max = 2 * ((1 << code_w) - 1 - ext_sub);
        return (lin_max > ext_max) ? lin_max : ext_max;
    endfunction

endpackage

// File: rtl/sclk_len_calc.sv
// Module: sclk_len_calc
// Turns a divider code and the stretch/correction controls into the low and
// high phase lengths of one serial clock period, plus a flag that says
// whether half-clock duty correction applies. Pure combinational logic.
// Assumes the code never selects a period shorter than two clocks.
module sclk_len_calc #(
    parameter int CODE_W    = 5,
    parameter int LIN_LIMIT = 16,
    parameter int LIN_ADD   = 2,
    parameter int EXT_SUB   = 7,
    parameter int PER_W     = 6,
    parameter int LEN_W     = 5,
    parameter bit FIX_EN    = 1'b1
) (
    input  logic [CODE_W-1:0] div_code,
    input  logic              tx_phase,
    input  logic              duty_fix,
    input  logic              setup_ext,
    input  logic              hold_ext,
    output logic [LEN_W-1:0]  lo_len,
    output logic [LEN_W-1:0]  hi_len,
    output logic              fix_on
);

    logic [PER_W-1:0] code_ext;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] half_dn;
    logic             lin_range;

    // Map the code onto a period: linear region first, doubled region above.
    always_comb begin
        code_ext  = PER_W'(div_code);
        lin_range = (code_ext < PER_W'(LIN_LIMIT));
        if (lin_range) begin
            period = code_ext + PER_W'(LIN_ADD);
        end else begin
            period = (code_ext - PER_W'(EXT_SUB)) << 1;
        end
        half_dn = period >> 1;
    end

    // Split the period (low gets the shorter half) and add transmit stretches.
    always_comb begin
        lo_len = LEN_W'(half_dn) + LEN_W'(tx_phase & setup_ext);
        hi_len = LEN_W'(period - half_dn) + LEN_W'(tx_phase & hold_ext);
        fix_on = FIX_EN & duty_fix & period[0];
    end

endmodule

// File: rtl/sclk_phase_gen.sv
// Module: sclk_phase_gen
// Phase counter that produces the undelayed serial clock and the edge
// strobes. Lengths and the correction select are latched at each period
// start, and continuously while idle, so a period runs to completion with
// the settings it started with. Assumes both lengths are at least one.
module sclk_phase_gen
    import sclkdiv_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [LEN_W-1:0] lo_len_in,
    input  logic [LEN_W-1:0] hi_len_in,
    input  logic             fix_in,
    output logic             sclk_raw,
    output logic             fix_sel,
    output logic             rise_stb,
    output logic             fall_stb
);

    phase_e           phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] lo_q;
    logic [LEN_W-1:0] hi_q;
    logic             fix_q;
    logic             rise_q;
    logic             fall_q;
    logic             low_done;
    logic             high_done;

    // Phase end detection against the latched lengths.
    always_comb begin
        low_done  = (phase_q == PH_LOW)  && (cnt_q == lo_q - LEN_W'(1));
        high_done = (phase_q == PH_HIGH) && (cnt_q == hi_q - LEN_W'(1));
    end

    // Phase counter, settings latch and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            lo_q    <= lo_len_in;
            hi_q    <= hi_len_in;
            fix_q   <= fix_in;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (low_done) begin
                phase_q <= PH_HIGH;
                cnt_q   <= '0;
                rise_q  <= 1'b1;
            end else if (high_done) begin
                phase_q <= PH_LOW;
                cnt_q   <= '0;
                fall_q  <= 1'b1;
                lo_q    <= lo_len_in;
                hi_q    <= hi_len_in;
                fix_q   <= fix_in;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    // Registered outputs straight from state.
    assign sclk_raw = (phase_q == PH_HIGH);
    assign fix_sel  = fix_q;
    assign rise_stb = rise_q;
    assign fall_stb = fall_q;

endmodule

// File: rtl/sclk_half_delay.sv
// Module: sclk_half_delay
// Delays the rising edge of the serial clock by half a peripheral clock
// when selected: a falling-edge copy of the raw clock is ANDed with it, so
// only the rise moves. The select changes only while the raw clock is low,
// so the output mux never switches while the clock is high.
module sclk_half_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic fix_sel,
    output logic sclk_out
);

    logic raw_neg_q;

    // Falling-edge capture of the raw clock.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            raw_neg_q <= 1'b0;
        end else begin
            raw_neg_q <= sclk_raw;
        end
    end

    // Output select: delayed-rise form or raw clock.
    assign sclk_out = fix_sel ? (sclk_raw & raw_neg_q) : sclk_raw;

endmodule

// File: rtl/sclk_divider.sv
// Module: sclk_divider (top)
// Serial flash clock generator: code-to-length mapping, phase counter and
// an optional half-clock duty corrector, chosen by FIX_EN. Clock idles low
// while run_en is low. Assumes all inputs are synchronous to clk.
module sclk_divider
    import sclkdiv_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int LIN_LIMIT = DEF_LIN_LIMIT,
    parameter int LIN_ADD   = DEF_LIN_ADD,
    parameter int EXT_SUB   = DEF_EXT_SUB,
    parameter bit FIX_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tx_phase,
    input  logic [CODE_W-1:0] div_code,
    input  logic              duty_fix,
    input  logic              setup_ext,
    input  logic              hold_ext,
    output logic              sclk,
    output logic              rise_stb,
    output logic              fall_stb
);

    localparam int MAX_PER = max_period(CODE_W, LIN_LIMIT, LIN_ADD, EXT_SUB);
    localparam int PER_W   = $clog2(MAX_PER + 1);
    localparam int LEN_W   = $clog2(MAX_PER / 2 + 2 + 1);

    logic [LEN_W-1:0] lo_len;
    logic [LEN_W-1:0] hi_len;
    logic             fix_on;
    logic             sclk_raw;
    logic             fix_sel;

    // Code and control decode.
    sclk_len_calc #(
        .CODE_W   (CODE_W),
        .LIN_LIMIT(LIN_LIMIT),
        .LIN_ADD  (LIN_ADD),
        .EXT_SUB  (EXT_SUB),
        .PER_W    (PER_W),
        .LEN_W    (LEN_W),
        .FIX_EN   (FIX_EN)
    ) u_len (
        .div_code (div_code),
        .tx_phase (tx_phase),
        .duty_fix (duty_fix),
        .setup_ext(setup_ext),
        .hold_ext (hold_ext),
        .lo_len   (lo_len),
        .hi_len   (hi_len),
        .fix_on   (fix_on)
    );

    // Phase counter and strobes.
    sclk_phase_gen #(
        .LEN_W(LEN_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .lo_len_in(lo_len),
        .hi_len_in(hi_len),
        .fix_in   (fix_on),
        .sclk_raw (sclk_raw),
        .fix_sel  (fix_sel),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    // Duty corrector only when the variant includes it.
    generate
        if (FIX_EN) begin : g_fix
            sclk_half_delay u_half (
                .clk     (clk),
                .rst_n   (rst_n),
                .sclk_raw(sclk_raw),
                .fix_sel (fix_sel),
                .sclk_out(sclk)
            );
        end else begin : g_nofix
            logic unused_sel;
            assign unused_sel = fix_sel;
            assign sclk       = sclk_raw;
        end
    endgenerate

endmodule

// File: rtl/sclk_divider_chk.sv
// Module: sclk_divider_chk
// Port-level properties of the serial clock divider, bound to the top.
module sclk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic sclk,
    input logic rise_stb,
    input logic fall_stb
);

    // R3: idle keeps the clock low and the strobes quiet.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!sclk && !rise_stb && !fall_stb));

    // R8: strobes never overlap.
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    // R8: rising strobe lasts one clock.
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    // R5, R8: by the end of a rising-strobe cycle the clock is high.
    a_r8_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> sclk);

    // R8: during a falling-strobe cycle the clock is low.
    a_r8_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> !sclk);

    // R8: every clock rise comes with a rising strobe.
    a_r8_rise_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> rise_stb);

    // R8: every fall while running comes with a falling strobe.
    a_r8_fall_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk) && $past(run_en)) |-> fall_stb);

endmodule

bind sclk_divider sclk_divider_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .sclk    (sclk),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
);

// File: tb/sclk_divider_tb.sv
module sclk_divider_tb;

    typedef struct packed {
        logic [4:0] code;
        logic       fix;
        logic       setup;
        logic       hold;
        logic       tx;
        logic [7:0] hi_half;
        logic [7:0] lo_half;
    } vec_t;

    localparam int NVEC = 13;
    // Expected widths in half peripheral clocks.
    localparam vec_t VECS [NVEC] = '{
        '{5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 8'd10, 8'd10},
        '{5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'd2,  8'd2 },
        '{5'd1,  1'b0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd2 },
        '{5'd1,  1'b1, 1'b0, 1'b0, 1'b0, 8'd3,  8'd3 },
        '{5'd15, 1'b0, 1'b0, 1'b0, 1'b0, 8'd18, 8'd16},
        '{5'd15, 1'b1, 1'b0, 1'b0, 1'b0, 8'd17, 8'd17},
        '{5'd16, 1'b1, 1'b0, 1'b0, 1'b0, 8'd18, 8'd18},
        '{5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 8'd48, 8'd48},
        '{5'd8,  1'b0, 1'b1, 1'b0, 1'b1, 8'd10, 8'd12},
        '{5'd8,  1'b0, 1'b0, 1'b1, 1'b1, 8'd12, 8'd10},
        '{5'd8,  1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 8'd10},
        '{5'd3,  1'b1, 1'b1, 1'b1, 1'b1, 8'd7,  8'd7 },
        '{5'd20, 1'b0, 1'b0, 1'b0, 1'b0, 8'd26, 8'd26}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       tx_phase = 1'b0;
    logic [4:0] div_code = 5'd8;
    logic       duty_fix = 1'b0;
    logic       setup_ext = 1'b0;
    logic       hold_ext = 1'b0;
    logic       sclk;
    logic       rise_stb;
    logic       fall_stb;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    sclk_divider u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tx_phase (tx_phase),
        .div_code (div_code),
        .duty_fix (duty_fix),
        .setup_ext(setup_ext),
        .hold_ext (hold_ext),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic half_step();
        @(clk);
        #1;
    endtask

    task automatic pos_step();
        @(posedge clk);
        #1;
    endtask

    // Rising edges until the given strobe is seen (bounded).
    task automatic edges_until(input bit want_rise, output int n);
        n = 0;
        do begin
            pos_step();
            n++;
        end while (((want_rise ? rise_stb : fall_stb) == 1'b0) && n < 200);
    endtask

    task automatic apply(input vec_t v);
        run_en    = 1'b0;
        div_code  = v.code;
        duty_fix  = v.fix;
        setup_ext = v.setup;
        hold_ext  = v.hold;
        tx_phase  = v.tx;
        for (int i = 0; i < 3; i++) pos_step();
        run_en = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int hi;
        int lo;
        int n;
        int act;
        string tag;

        // R3: reset holds the clock low even with enable high.
        run_en = 1'b1;
        act = 0;
        for (int i = 0; i < 6; i++) begin
            pos_step();
            act += int'(sclk) + int'(rise_stb) + int'(fall_stb);
        end
        chk("R3 reset quiet", act, 0);
        run_en = 1'b0;
        pos_step();
        rst_n = 1'b1;

        // R3: idle stays low.
        act = 0;
        for (int i = 0; i < 40; i++) begin
            half_step();
            act += int'(sclk) + int'(rise_stb) + int'(fall_stb);
        end
        chk("R3 idle quiet", act, 0);

        // Vector table: phase widths in half clocks.
        for (int k = 0; k < NVEC; k++) begin
            apply(VECS[k]);
            n = 0;
            while (sclk == 1'b0 && n < 400) begin half_step(); n++; end
            hi = 0;
            while (sclk == 1'b1 && hi < 400) begin hi++; half_step(); end
            lo = 0;
            while (sclk == 1'b0 && lo < 400) begin lo++; half_step(); end
            if (VECS[k].setup | VECS[k].hold) tag = "R6";
            else if (VECS[k].fix)             tag = "R5";
            else if (VECS[k].code < 5'd16)    tag = "R1";
            else                              tag = "R2";
            chk({tag, " high width"}, hi, int'(VECS[k].hi_half));
            chk({tag, " low width"}, lo, int'(VECS[k].lo_half));
        end

        // R4: start latency equals the low length (code 8 -> 5).
        apply('{5'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0});
        run_en = 1'b0;
        pos_step();
        run_en = 1'b1;
        edges_until(1'b1, n);
        chk("R4 start latency", n, 5);
        // R4 with setup stretch during transmit -> 6.
        apply('{5'd8, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0, 8'd0});
        run_en = 1'b0;
        pos_step();
        run_en = 1'b1;
        edges_until(1'b1, n);
        chk("R4 stretched start latency", n, 6);

        // R7: code change mid-high finishes old period (high 5), then 1/1.
        apply('{5'd8, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0});
        edges_until(1'b1, n);
        div_code = 5'd0;
        edges_until(1'b0, n);
        chk("R7 old high kept", n, 5);
        edges_until(1'b1, n);
        chk("R7 new low", n, 1);
        edges_until(1'b0, n);
        chk("R7 new high", n, 1);

        // R5/R8: with correction, strobe leads the delayed rise by half a clock.
        apply('{5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0});
        edges_until(1'b1, n);
        chk("R8 strobe before delayed rise", int'(sclk), 0);
        @(negedge clk);
        #1;
        chk("R5 delayed rise seen", int'(sclk), 1);
        pos_step();
        chk("R8 rise strobe one clock", int'(rise_stb), 0);
        edges_until(1'b0, n);
        chk("R8 fall strobe with low clock", int'(sclk), 0);

        // R3: dropping enable returns to idle low.
        run_en = 1'b0;
        pos_step();
        act = 0;
        for (int i = 0; i < 20; i++) begin
            half_step();
            act += int'(sclk) + int'(rise_stb) + int'(fall_stb);
        end
        chk("R3 disable quiet", act, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule